// File: doc/BRIEF.md
# Light-Sharing Crystal Position Decoder

This block takes one scintillation event from a detector module in which a block of crystals shares its light over four photodetectors. Each event arrives as four digitized pulse amplitudes and a time stamp, qualified by a single-cycle valid strobe. The block adds the four amplitudes to form the event energy. A pair of shift-subtract dividers then forms two normalized light-sharing ratios: one vertical, one horizontal. Each ratio is quantized to a grid index. The two indices address a loadable position table, and the table returns the crystal ID of the interaction.

A second loadable table holds an energy window for each crystal, with inclusive lower and upper bounds. The decoded crystal selects its window, and the energy is tested against it to decide whether the hit is a photopeak event. Every accepted event leaves as one formatted result: crystal ID, energy, time stamp and a pass flag, with a one-cycle output strobe. An event that fails the window is still emitted, with the flag clear. While an event is being processed the block raises `busy`, and strobes that arrive in that time are not taken.

With the default parameters, amplitudes are 12 bits wide and the energy 14 bits. Ratios carry 6 fractional bits, each grid index is 4 bits, and crystal IDs run from 1 to 56, numbered row-major over a 7-column by 8-row array. ID 0 means no crystal.

Top module: `anger_decoder`

## Requirements
- R1: The emitted energy equals A + B + C + D of the accepted event, with no truncation (14 bits by default).
- R2: The vertical ratio is floor(64*(A+B)/E) and the horizontal ratio is floor(64*(B+D)/E). A ratio of 64 maps to grid index 15; any other ratio maps to ratio/4. The position table address is (vertical index)*16 + (horizontal index), and the emitted crystal ID is the table entry at that address.
- R3: A position-table write (`posWrEn`, `posWrAddr`, `posWrId`) takes effect for every event accepted after the write cycle. A window write (`winWrEn`, `winWrId`, `winWrLo`, `winWrHi`) works the same way.
- R4: `outPass` is 1 only when the crystal ID is in 1..56 and lo <= E <= hi for that crystal's window. Events that fail are still emitted, with `outPass` = 0.
- R5: An event with E = 0 skips the division. It is emitted with crystal ID 0 and `outPass` = 0, on the second clock edge after the accepting edge.
- R6: For E != 0, `outValid` is high for exactly one cycle, following the tenth clock edge after the accepting edge. `outStamp` carries the accepted time stamp.
- R7: `busy` is high from the accepting edge through the strobe cycle. `inValid` asserted while `busy` is high is ignored: it produces no event and does not alter the pending one.
- R8: After reset, `outValid` and `busy` are 0, and every position-table entry and window is cleared, so an event decodes to crystal 0 and fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Event strobe for amplitudes and stamp |
| ampA | input | 12 | Amplitude of channel A |
| ampB | input | 12 | Amplitude of channel B |
| ampC | input | 12 | Amplitude of channel C |
| ampD | input | 12 | Amplitude of channel D |
| stampIn | input | 16 | Time stamp of the event |
| posWrEn | input | 1 | Position table write enable |
| posWrAddr | input | 8 | Position table address (vertical index high) |
| posWrId | input | 6 | Crystal ID to store |
| winWrEn | input | 1 | Energy window write enable |
| winWrId | input | 6 | Crystal whose window is written |
| winWrLo | input | 14 | Lower energy bound, inclusive |
| winWrHi | input | 14 | Upper energy bound, inclusive |
| busy | output | 1 | Event in progress; new strobes ignored |
| outValid | output | 1 | One-cycle result strobe |
| outCrystal | output | 6 | Decoded crystal ID, 0 if none |
| outEnergy | output | 14 | Event energy |
| outStamp | output | 16 | Time stamp of the event |
| outPass | output | 1 | Energy inside the crystal's window |

## Verification
A bad divider remainder or step count shows up as a wrong crystal ID on that event's strobe. The same fault can also show up as a latency that is not exactly ten edges. Because each event restarts the divider, a corrupted remainder never carries over to the next event. A state machine that lets a strobe through while busy gives an extra strobe, or the wrong stamp, within a dozen cycles. A stale window or table entry shows only when an event lands on that crystal, which is why the bench rewrites entries and sends events that land exactly on the window edges.

// File: rtl/anger_pkg.sv
package anger_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIVIDE,
    ST_LOOKUP,
    ST_JUDGE,
    ST_EMIT
  } anger_state_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic load;    // capture amplitudes, start a new event
    logic step;    // one divider iteration
    logic lookup;  // register crystal ID from position table
    logic judge;   // register energy window decision
  } anger_ctl_t;

endpackage

// File: rtl/anger_ratio_div.sv
module anger_ratio_div #(
  parameter int DEN_W  = 14,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              step,
  input  logic [DEN_W-1:0]  num,
  input  logic [DEN_W-1:0]  den,
  output logic [FRAC_W:0]   quo
);

  logic [DEN_W:0] rem;
  logic [DEN_W:0] denExt;
  logic [DEN_W:0] remKeep;
  logic           geBit;

  assign denExt  = {1'b0, den};
  assign geBit   = (rem >= denExt);
  assign remKeep = geBit ? (rem - denExt) : rem;

  // restoring division, one quotient bit per step, MSB (integer bit) first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem <= '0;
      quo <= '0;
    end else if (load) begin
      rem <= {1'b0, num};
      quo <= '0;
    end else if (step) begin
      rem <= {remKeep[DEN_W-1:0], 1'b0};
      quo <= {quo[FRAC_W-1:0], geBit};
    end
  end

endmodule

// File: rtl/anger_dp.sv
module anger_dp
  import anger_pkg::*;
#(
  parameter int AMP_W       = 12,
  parameter int FRAC_W      = 6,
  parameter int QUANT_W     = 4,
  parameter int ID_W        = 6,
  parameter int NUM_CRYSTAL = 56,
  parameter int TS_W        = 16,
  localparam int EN_W       = AMP_W + 2,
  localparam int ADDR_W     = 2 * QUANT_W,
  localparam int POS_DEPTH  = 1 << ADDR_W,
  localparam int WIN_DEPTH  = 1 << ID_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  anger_ctl_t        ctl,
  input  logic [AMP_W-1:0]  ampA,
  input  logic [AMP_W-1:0]  ampB,
  input  logic [AMP_W-1:0]  ampC,
  input  logic [AMP_W-1:0]  ampD,
  input  logic [TS_W-1:0]   stampIn,
  input  logic              posWrEn,
  input  logic [ADDR_W-1:0] posWrAddr,
  input  logic [ID_W-1:0]   posWrId,
  input  logic              winWrEn,
  input  logic [ID_W-1:0]   winWrId,
  input  logic [EN_W-1:0]   winWrLo,
  input  logic [EN_W-1:0]   winWrHi,
  output logic              eZero,
  output logic [ID_W-1:0]   crystalQ,
  output logic [EN_W-1:0]   energyQ,
  output logic [TS_W-1:0]   stampQ,
  output logic              passQ
);

  logic [EN_W-1:0]   sumAll;
  logic [EN_W-1:0]   numIn [2];   // 0: vertical, 1: horizontal
  logic [FRAC_W:0]   quo   [2];
  logic [ADDR_W-1:0] rdAddr;
  logic [ID_W-1:0]   posTbl [POS_DEPTH];
  logic [EN_W-1:0]   winLo  [WIN_DEPTH];
  logic [EN_W-1:0]   winHi  [WIN_DEPTH];
  logic              idInRange;

  assign sumAll   = EN_W'(ampA) + EN_W'(ampB) + EN_W'(ampC) + EN_W'(ampD);
  assign numIn[0] = EN_W'(ampA) + EN_W'(ampB);
  assign numIn[1] = EN_W'(ampB) + EN_W'(ampD);

  for (genvar g = 0; g < 2; g++) begin : g_axis
    anger_ratio_div #(
      .DEN_W  (EN_W),
      .FRAC_W (FRAC_W)
    ) u_div (
      .clk  (clk),
      .rstN (rstN),
      .load (ctl.load),
      .step (ctl.step),
      .num  (numIn[g]),
      .den  (energyQ),
      .quo  (quo[g])
    );
  end

  // a ratio of exactly 1.0 saturates to the last grid cell
  function automatic logic [QUANT_W-1:0] gridIdx(input logic [FRAC_W:0] q);
    if (q[FRAC_W]) return '1;
    return q[FRAC_W-1 -: QUANT_W];
  endfunction

  assign rdAddr    = {gridIdx(quo[0]), gridIdx(quo[1])};
  assign idInRange = (crystalQ != '0) && (int'(crystalQ) <= NUM_CRYSTAL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < POS_DEPTH; i++) posTbl[i] <= '0;
    end else if (posWrEn) begin
      posTbl[posWrAddr] <= posWrId;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WIN_DEPTH; i++) begin
        winLo[i] <= '0;
        winHi[i] <= '0;
      end
    end else if (winWrEn) begin
      winLo[winWrId] <= winWrLo;
      winHi[winWrId] <= winWrHi;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      energyQ  <= '0;
      stampQ   <= '0;
      eZero    <= 1'b0;
      crystalQ <= '0;
      passQ    <= 1'b0;
    end else begin
      if (ctl.load) begin
        energyQ  <= sumAll;
        stampQ   <= stampIn;
        eZero    <= (sumAll == '0);
        crystalQ <= '0;
        passQ    <= 1'b0;
      end
      if (ctl.lookup) crystalQ <= posTbl[rdAddr];
      if (ctl.judge) begin
        passQ <= idInRange && (energyQ >= winLo[crystalQ])
                           && (energyQ <= winHi[crystalQ]);
      end
    end
  end

endmodule

// File: rtl/anger_ctrl.sv
module anger_ctrl
  import anger_pkg::*;
#(
  parameter int FRAC_W = 6,
  localparam int STEPS = FRAC_W + 1,
  localparam int CNT_W = $clog2(STEPS + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       eZero,
  output anger_ctl_t ctl,
  output logic       busy,
  output logic       outValid
);

  anger_state_e state, stateNext;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (inValid) begin
          ctl.load  = 1'b1;
          stateNext = ST_DIVIDE;
        end
      end
      ST_DIVIDE: begin
        if (eZero) begin
          stateNext = ST_EMIT;
        end else begin
          ctl.step = 1'b1;
          if (stepCnt == CNT_W'(STEPS - 1)) stateNext = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        ctl.lookup = 1'b1;
        stateNext  = ST_JUDGE;
      end
      ST_JUDGE: begin
        ctl.judge = 1'b1;
        stateNext = ST_EMIT;
      end
      ST_EMIT:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      state <= stateNext;
      if (ctl.load)      stepCnt <= '0;
      else if (ctl.step) stepCnt <= stepCnt + 1'b1;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign outValid = (state == ST_EMIT);

endmodule

// File: rtl/anger_decoder.sv
module anger_decoder
  import anger_pkg::*;
#(
  parameter int AMP_W       = 12,
  parameter int FRAC_W      = 6,
  parameter int QUANT_W     = 4,
  parameter int ID_W        = 6,
  parameter int NUM_CRYSTAL = 56,
  parameter int TS_W        = 16,
  localparam int EN_W       = AMP_W + 2,
  localparam int ADDR_W     = 2 * QUANT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [AMP_W-1:0]  ampA,
  input  logic [AMP_W-1:0]  ampB,
  input  logic [AMP_W-1:0]  ampC,
  input  logic [AMP_W-1:0]  ampD,
  input  logic [TS_W-1:0]   stampIn,
  input  logic              posWrEn,
  input  logic [ADDR_W-1:0] posWrAddr,
  input  logic [ID_W-1:0]   posWrId,
  input  logic              winWrEn,
  input  logic [ID_W-1:0]   winWrId,
  input  logic [EN_W-1:0]   winWrLo,
  input  logic [EN_W-1:0]   winWrHi,
  output logic              busy,
  output logic              outValid,
  output logic [ID_W-1:0]   outCrystal,
  output logic [EN_W-1:0]   outEnergy,
  output logic [TS_W-1:0]   outStamp,
  output logic              outPass
);

  anger_ctl_t ctl;
  logic       eZero;

  anger_ctrl #(.FRAC_W(FRAC_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .eZero    (eZero),
    .ctl      (ctl),
    .busy     (busy),
    .outValid (outValid)
  );

  anger_dp #(
    .AMP_W       (AMP_W),
    .FRAC_W      (FRAC_W),
    .QUANT_W     (QUANT_W),
    .ID_W        (ID_W),
    .NUM_CRYSTAL (NUM_CRYSTAL),
    .TS_W        (TS_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .ampA      (ampA),
    .ampB      (ampB),
    .ampC      (ampC),
    .ampD      (ampD),
    .stampIn   (stampIn),
    .posWrEn   (posWrEn),
    .posWrAddr (posWrAddr),
    .posWrId   (posWrId),
    .winWrEn   (winWrEn),
    .winWrId   (winWrId),
    .winWrLo   (winWrLo),
    .winWrHi   (winWrHi),
    .eZero     (eZero),
    .crystalQ  (outCrystal),
    .energyQ   (outEnergy),
    .stampQ    (outStamp),
    .passQ     (outPass)
  );

endmodule

// File: rtl/anger_decoder_checker.sv
module anger_decoder_checker #(
  parameter int ID_W = 6,
  parameter int EN_W = 14
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic            busy,
  input logic            outValid,
  input logic [ID_W-1:0] outCrystal,
  input logic [EN_W-1:0] outEnergy,
  input logic            outPass
);

  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  a_r7_busy_covers_strobe: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy);

  a_r7_accept_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !busy) |=> busy);

  a_r5_zero_energy_no_crystal: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outEnergy == '0) |-> (outCrystal == '0 && !outPass));

  a_r4_pass_needs_crystal: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outPass) |-> (outCrystal != '0));

  a_r7_busy_ends_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !outValid) |=> busy);

endmodule

bind anger_decoder anger_decoder_checker #(.ID_W(ID_W), .EN_W(EN_W)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .busy       (busy),
  .outValid   (outValid),
  .outCrystal (outCrystal),
  .outEnergy  (outEnergy),
  .outPass    (outPass)
);

// File: tb/anger_decoder_bench.sv
module anger_decoder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [11:0] ampA = '0, ampB = '0, ampC = '0, ampD = '0;
  logic [15:0] stampIn = '0;
  logic        posWrEn = 1'b0;
  logic [7:0]  posWrAddr = '0;
  logic [5:0]  posWrId = '0;
  logic        winWrEn = 1'b0;
  logic [5:0]  winWrId = '0;
  logic [13:0] winWrLo = '0, winWrHi = '0;
  logic        busy, outValid, outPass;
  logic [5:0]  outCrystal;
  logic [13:0] outEnergy;
  logic [15:0] outStamp;

  int errors = 0;
  int checks = 0;
  int posModel [256];
  int loModel  [64];
  int hiModel  [64];

  localparam int NVEC = 12;
  localparam int VA [NVEC] = '{400, 900, 100,  50, 1000,  20, 4095,    0, 1, 700, 123, 3000};
  localparam int VB [NVEC] = '{400, 100, 900,  60,   50, 700, 4095,    0, 0, 700, 456,   10};
  localparam int VC [NVEC] = '{400, 300, 200, 700,   50,  30,    0,    0, 0, 700, 789,   10};
  localparam int VD [NVEC] = '{400, 200, 300, 800,  400, 900,    0, 4095, 0, 700, 321, 3000};

  always #10 clk = ~clk;

  anger_decoder u_anger_decoder (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .ampA(ampA), .ampB(ampB), .ampC(ampC), .ampD(ampD), .stampIn(stampIn),
    .posWrEn(posWrEn), .posWrAddr(posWrAddr), .posWrId(posWrId),
    .winWrEn(winWrEn), .winWrId(winWrId), .winWrLo(winWrLo), .winWrHi(winWrHi),
    .busy(busy), .outValid(outValid), .outCrystal(outCrystal),
    .outEnergy(outEnergy), .outStamp(outStamp), .outPass(outPass)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int gridOf(input int num, input int e);
    int q;
    q = (num * 64) / e;
    if (q >= 64) return 15;
    return q / 4;
  endfunction

  function automatic int addrOf(input int a, input int b, input int c, input int d);
    int e;
    e = a + b + c + d;
    return gridOf(a + b, e) * 16 + gridOf(b + d, e);
  endfunction

  task automatic writePos(input int addr, input int id);
    @(negedge clk);
    posWrEn = 1'b1; posWrAddr = 8'(addr); posWrId = 6'(id);
    @(negedge clk);
    posWrEn = 1'b0;
    posModel[addr] = id;
  endtask

  task automatic writeWin(input int id, input int lo, input int hi);
    @(negedge clk);
    winWrEn = 1'b1; winWrId = 6'(id); winWrLo = 14'(lo); winWrHi = 14'(hi);
    @(negedge clk);
    winWrEn = 1'b0;
    loModel[id] = lo;
    hiModel[id] = hi;
  endtask

  // send one event and compare against the model
  task automatic runEvent(input int a, input int b, input int c, input int d, input int ts);
    int e, expId, expLat, n;
    bit expPass;
    e = a + b + c + d;
    if (e == 0) begin
      expId = 0; expLat = 2;
    end else begin
      expId = posModel[addrOf(a, b, c, d)]; expLat = 10;
    end
    expPass = (expId != 0) && (expId <= 56) && (e >= loModel[expId]) && (e <= hiModel[expId]);
    @(negedge clk);
    inValid = 1'b1;
    ampA = 12'(a); ampB = 12'(b); ampC = 12'(c); ampD = 12'(d); stampIn = 16'(ts);
    @(negedge clk);
    inValid = 1'b0;
    n = 1;
    while (!outValid && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(n == expLat, (e == 0) ? "R5 latency" : "R6 latency", n, expLat);
    check(int'(outEnergy) == e, "R1 energy", int'(outEnergy), e);
    check(int'(outCrystal) == expId, (e == 0) ? "R5 crystal" : "R2 crystal", int'(outCrystal), expId);
    check(outPass == expPass, "R4 pass flag", int'(outPass), int'(expPass));
    check(int'(outStamp) == ts, "R6 stamp", int'(outStamp), ts);
    @(negedge clk);
    check(!outValid, "R6 single strobe", int'(outValid), 0);
  endtask

  initial begin
    int tgtAddr, tgtId, extra;
    for (int i = 0; i < 256; i++) posModel[i] = 0;
    for (int i = 0; i < 64; i++) begin loModel[i] = 0; hiModel[i] = 0; end

    repeat (3) @(negedge clk);
    check(!outValid && !busy, "R8 reset outputs", int'(outValid) + 2 * int'(busy), 0);
    rstN = 1'b1;

    // R8: cleared tables decode to crystal 0, fail
    runEvent(400, 400, 400, 400, 5);

    // load row-major 7x8 map over the 16x16 grid, windows per crystal
    for (int yi = 0; yi < 16; yi++)
      for (int xi = 0; xi < 16; xi++)
        writePos(yi * 16 + xi, (yi * 8 / 16) * 7 + (xi * 7 / 16) + 1);
    for (int id = 1; id <= 56; id++) writeWin(id, 1000 + 10 * id, 1700 + 10 * id);

    // R1, R2, R4, R6: vector walk
    for (int v = 0; v < NVEC; v++) runEvent(VA[v], VB[v], VC[v], VD[v], v * 1111 + 7);

    // R5: zero energy with a nonzero stamp
    runEvent(0, 0, 0, 0, 16'hBEEF);

    // R4: inclusive window edges
    tgtAddr = addrOf(400, 400, 400, 400);
    tgtId = posModel[tgtAddr];
    writeWin(tgtId, 1600, 1600);
    runEvent(400, 400, 400, 400, 11);
    check(outPass == 1'b1, "R4 energy on both bounds", int'(outPass), 1);
    writeWin(tgtId, 1601, 2000);
    runEvent(400, 400, 400, 400, 12);
    writeWin(tgtId, 0, 1599);
    runEvent(400, 400, 400, 400, 13);

    // R3, R4: unmapped entry, then rewrite
    writePos(tgtAddr, 0);
    runEvent(400, 400, 400, 400, 14);
    writePos(tgtAddr, 55);
    writeWin(55, 0, 16383);
    runEvent(400, 400, 400, 400, 15);
    check(int'(outCrystal) == 55, "R3 rewritten entry", int'(outCrystal), 55);

    // R7: strobes while busy are ignored
    @(negedge clk);
    inValid = 1'b1; ampA = 12'd900; ampB = 12'd100; ampC = 12'd300; ampD = 12'd200; stampIn = 16'd77;
    @(negedge clk);
    ampA = 12'd5; ampB = 12'd6; ampC = 12'd7; ampD = 12'd8; stampIn = 16'd99;
    check(busy, "R7 busy after accept", int'(busy), 1);
    repeat (5) @(negedge clk);
    inValid = 1'b0;
    while (!outValid) @(negedge clk);
    check(int'(outStamp) == 77, "R7 pending stamp kept", int'(outStamp), 77);
    check(int'(outEnergy) == 1500, "R7 pending energy kept", int'(outEnergy), 1500);
    extra = 0;
    repeat (20) begin
      @(negedge clk);
      if (outValid) extra++;
    end
    check(extra == 0, "R7 no extra event", extra, 0);
    check(!busy, "R7 idle after strobe", int'(busy), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule